// File: doc/BRIEF.md
# Asynchronous Peripheral Byte Loader with Serial Output

This block accepts bytes from a microprocessor-style bus and turns them into a serial bit stream, one bit per configuration clock. The host writes a byte with a strobe that is not related to the configuration clock. The strobe and the select lines are qualified by two active-low selects, one active-high select and an active-low write strobe. Each accepted byte goes into a holding register. From there it moves into a shift register, which sends it out least significant bit first. Because there are two buffer levels, the host can write the next byte while the current one is still being shifted out.

A busy flag tells the host when the holding register is occupied. Busy is short when the shifter is idle, because the byte passes straight through. Busy is long when the shifter is still sending the previous byte. The host can read busy back with a status-read cycle, which places a ready bit on the top data bit. A write that ends while busy is high is discarded, and it sets a sticky overrun flag.

Top module: `cfg_byte_loader`

## Requirements
- R1: After synchronous reset `busy`, `overrun`, `ser_out` and `rd_oe` are 0.
- R2: A write is qualified when `sel0_n`=0, `sel1`=1, `stat_n`=1 and `wstb_n`=0, held for at least 2 clock cycles. The byte taken is the `wr_data` value sampled at the last clock edge on which the qualifier was seen true. Data is not needed after the strobe ends.
- R3: Let e be the first rising edge that samples the write as ended. If the holding register is empty, `busy` is 1 after edge e+2.
- R4: When the shifter is idle, an accepted byte moves on at the next edge, so `busy` is high for exactly one clock cycle.
- R5: The held byte moves to the shifter only on an edge where the shifter has at most one bit left. `busy` falls on that same edge, so busy lasts longer while a previous byte is still shifting.
- R6: A byte that enters the shifter appears on `ser_out` from the next edge, bit 0 first, one bit per clock. The next byte follows the last bit with no gap.
- R7: While no bits are pending, `ser_out` keeps its last value.
- R8: A write whose end is detected while `busy` is 1 is discarded, and the held byte is unchanged. `overrun` then rises and stays 1 until reset.
- R9: While `sel0_n`=0, `sel1`=1 and `stat_n`=0, `rd_oe` is 1 and `rd_data` equals {~busy, 7'b0}, combinationally. Otherwise `rd_oe` is 0 and `rd_data` is 0. A read never starts a write.
- R10: A write strobe that comes with a non-qualifying select pattern has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| sel0_n | input | 1 | Active-low chip select |
| sel1 | input | 1 | Active-high chip select |
| stat_n | input | 1 | Active-low status-read select (high for writes) |
| wstb_n | input | 1 | Active-low asynchronous write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Status byte, bit 7 = ready |
| rd_oe | output | 1 | Status byte drive enable |
| ser_out | output | 1 | Serial data, LSB first |
| busy | output | 1 | Holding register occupied |
| overrun | output | 1 | Sticky flag for a discarded write |

## Verification
From the first edge that samples a write as ended, three register stages lie before the holding register updates. A transfer into the shifter follows one edge after that, and the first serial bit one edge after the transfer. The bench keeps a delayed-history reference model that uses those same counts. It compares `busy`, `overrun` and `ser_out` at every falling edge, after all registers have settled. The combinational status read is checked a few nanoseconds after the inputs are driven. The directed checks cover the following:
- the one-cycle busy pulse;
- the serial order of a byte whose data changed during the strobe;
- three back-to-back writes, where the third must overrun.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    parameter int BYTE_W      = 8;
    parameter int SYNC_STAGES = 2;
    localparam int CNT_W      = $clog2(BYTE_W + 1);

    // Host-side control lines, kept together for synchronisation.
    typedef struct packed {
        logic sel0_n;
        logic sel1;
        logic stat_n;
        logic wstb_n;
    } host_ctl_t;

    localparam host_ctl_t CTL_IDLE = '{sel0_n: 1'b1, sel1: 1'b0,
                                       stat_n: 1'b1, wstb_n: 1'b1};

    function automatic logic is_write(input host_ctl_t c);
        return !c.sel0_n && c.sel1 && c.stat_n && !c.wstb_n;
    endfunction

    function automatic logic is_status_read(input host_ctl_t c);
        return !c.sel0_n && c.sel1 && !c.stat_n;
    endfunction

endpackage

// File: rtl/cfg_strobe_sync.sv
module cfg_strobe_sync
    import cfg_loader_pkg::*;
#(
    parameter int W      = BYTE_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  host_ctl_t    ctl_raw,
    input  logic [W-1:0] data_raw,
    output logic         wr_end,
    output logic [W-1:0] wr_byte
);
    localparam int LAST = STAGES - 1;

    host_ctl_t    ctl_q  [STAGES];
    logic [W-1:0] data_q [STAGES];
    logic         wr_now;
    logic         wr_prev;
    logic [W-1:0] byte_lat;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    ctl_q[g]  <= CTL_IDLE;
                    data_q[g] <= '0;
                end else begin
                    ctl_q[g]  <= ctl_raw;
                    data_q[g] <= data_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    ctl_q[g]  <= CTL_IDLE;
                    data_q[g] <= '0;
                end else begin
                    ctl_q[g]  <= ctl_q[g-1];
                    data_q[g] <= data_q[g-1];
                end
            end
        end
    end

    assign wr_now = is_write(ctl_q[LAST]);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev  <= 1'b0;
            byte_lat <= '0;
        end else begin
            wr_prev <= wr_now;
            if (wr_now) begin
                byte_lat <= data_q[LAST];
            end
        end
    end

    assign wr_end  = wr_prev && !wr_now;
    assign wr_byte = byte_lat;

endmodule

// File: rtl/cfg_hold_stage.sv
module cfg_hold_stage
    import cfg_loader_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_end,
    input  logic [W-1:0] wr_byte,
    input  logic         xfer,
    output logic         full,
    output logic [W-1:0] held,
    output logic         overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            held    <= '0;
            overrun <= 1'b0;
        end else begin
            if (xfer) begin
                full <= 1'b0;
            end
            if (wr_end) begin
                if (full) begin
                    overrun <= 1'b1;
                end else begin
                    held <= wr_byte;
                    full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_shift_stage.sv
module cfg_shift_stage
    import cfg_loader_pkg::*;
#(
    parameter int W   = BYTE_W,
    parameter int CW  = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_byte,
    output logic          ser_out,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] FULL_CNT = CW'(W);

    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            cnt     <= '0;
            ser_out <= 1'b0;
        end else begin
            if (cnt != '0) begin
                ser_out <= sreg[0];
            end
            if (load) begin
                sreg <= load_byte;
                cnt  <= FULL_CNT;
            end else if (cnt != '0) begin
                sreg <= sreg >> 1;
                cnt  <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfg_loader_pkg::*;
#(
    parameter int W      = BYTE_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel0_n,
    input  logic         sel1,
    input  logic         stat_n,
    input  logic         wstb_n,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         rd_oe,
    output logic         ser_out,
    output logic         busy,
    output logic         overrun
);
    localparam int CW = $clog2(W + 1);

    host_ctl_t     ctl_raw;
    logic          wr_end;
    logic [W-1:0]  wr_byte;
    logic [W-1:0]  held;
    logic          xfer;
    logic [CW-1:0] sh_cnt;

    assign ctl_raw = '{sel0_n: sel0_n, sel1: sel1, stat_n: stat_n, wstb_n: wstb_n};

    cfg_strobe_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ctl_raw  (ctl_raw),
        .data_raw (wr_data),
        .wr_end   (wr_end),
        .wr_byte  (wr_byte)
    );

    cfg_hold_stage #(.W(W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_end  (wr_end),
        .wr_byte (wr_byte),
        .xfer    (xfer),
        .full    (busy),
        .held    (held),
        .overrun (overrun)
    );

    // Hand off only when the shifter sends its final bit this cycle or is idle.
    assign xfer = busy && (sh_cnt <= CW'(1));

    cfg_shift_stage #(.W(W), .CW(CW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (xfer),
        .load_byte (held),
        .ser_out   (ser_out),
        .cnt       (sh_cnt)
    );

    // Status read path is combinational from the bus pins.
    always_comb begin
        rd_oe   = is_status_read(ctl_raw);
        rd_data = '0;
        if (rd_oe) begin
            rd_data[W-1] = !busy;
        end
    end
endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk #(
    parameter int CW = 4,
    parameter int W  = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          ser_out,
    input logic          overrun,
    input logic          xfer,
    input logic [CW-1:0] sh_cnt
);
    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R5
    busy_drop_at_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(sh_cnt) <= CW'(1));

    // R4
    short_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && sh_cnt == '0) |=> !busy);

    // R6
    load_count_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> sh_cnt == CW'(W));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_cnt != '0 && !xfer) |=> sh_cnt == $past(sh_cnt) - 1'b1);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_cnt == '0 && !xfer) |=> $stable(ser_out));
endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(.CW(CW), .W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .ser_out (ser_out),
    .overrun (overrun),
    .xfer    (xfer),
    .sh_cnt  (sh_cnt)
);

// File: tb/cfg_byte_loader_tb.sv
module cfg_byte_loader_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel0_n = 1'b1;
    logic       sel1 = 1'b0;
    logic       stat_n = 1'b1;
    logic       wstb_n = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_oe;
    logic       ser_out;
    logic       busy;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_byte_loader u_dut (
        .clk(clk), .rst(rst), .sel0_n(sel0_n), .sel1(sel1), .stat_n(stat_n),
        .wstb_n(wstb_n), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .ser_out(ser_out), .busy(busy), .overrun(overrun)
    );

    // ---------------- reference model ----------------
    bit       h_w [3];
    bit [7:0] h_d [3];
    bit       m_busy, m_ovr, m_dout;
    bit [7:0] m_hold;
    bit       bitq [$];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin h_w[i] = 0; h_d[i] = 0; end
            m_busy = 0; m_ovr = 0; m_dout = 0; m_hold = 0;
            bitq.delete();
        end else begin
            bit ev, ob, xf;
            bit [7:0] by;
            ev = h_w[2] && !h_w[1];
            by = h_d[2];
            ob = m_busy;
            xf = ob && (bitq.size() <= 1);
            if (bitq.size() > 0) m_dout = bitq.pop_front();
            if (xf) begin
                for (int i = 0; i < 8; i++) bitq.push_back(m_hold[i]);
                m_busy = 0;
            end
            if (ev) begin
                if (ob) m_ovr = 1;
                else begin m_hold = by; m_busy = 1; end
            end
            h_w[2] = h_w[1]; h_d[2] = h_d[1];
            h_w[1] = h_w[0]; h_d[1] = h_d[0];
            h_w[0] = !sel0_n && sel1 && stat_n && !wstb_n;
            h_d[0] = wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison of the registered outputs
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(busy == m_busy, "R3 R4 R5 busy", busy, m_busy);
            check(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
            check(ser_out == m_dout, "R6 R7 ser_out", ser_out, m_dout);
        end
    end

    task automatic do_write(input bit [7:0] d0, input bit [7:0] d1, input bit good);
        @(negedge clk);
        sel0_n = good ? 1'b0 : 1'b1; sel1 = 1'b1; stat_n = 1'b1;
        wstb_n = 1'b0; wr_data = d0;
        @(negedge clk);
        wr_data = d1;
        @(negedge clk);
        wstb_n = 1'b1; wr_data = ~d1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        sel0_n = 1'b1; sel1 = 1'b0; stat_n = 1'b1; wstb_n = 1'b1;
    endtask

    task automatic status_read(input string req);
        @(negedge clk);
        sel0_n = 1'b0; sel1 = 1'b1; stat_n = 1'b0; wstb_n = 1'b1;
        #3;
        check(rd_oe == 1'b1, req, rd_oe, 1);
        check(rd_data == {~m_busy, 7'b0}, req, rd_data, {~m_busy, 7'b0});
        @(negedge clk);
        sel0_n = 1'b1; sel1 = 1'b0; stat_n = 1'b1;
        #3;
        check(rd_oe == 1'b0 && rd_data == 8'h00, req, {rd_oe, rd_data}, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        bit [7:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && overrun == 0 && ser_out == 0 && rd_oe == 0,
              "R1 reset", {busy, overrun, ser_out, rd_oe}, 0);

        // R4 single-cycle busy into idle shifter
        do_write(8'h11, 8'hA5, 1'b1);
        cnt = 0;
        repeat (12) begin @(negedge clk); if (busy) cnt++; end
        check(cnt == 1, "R4 short busy length", cnt, 1);
        idle(8);

        // R2 byte is the last sampled data; R6 LSB-first order
        do_write(8'hFF, 8'h3C, 1'b1);
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            got[i] = ser_out;
        end
        check(got == 8'h3C, "R2 R6 serial byte", got, 8'h3C);

        // R7 idle hold
        cnt = 0;
        repeat (10) begin @(negedge clk); if (ser_out != got[7]) cnt++; end
        check(cnt == 0, "R7 idle hold", cnt, 0);

        // R10 wrong select has no effect
        do_write(8'h77, 8'h77, 1'b0);
        cnt = 0;
        repeat (8) begin @(negedge clk); if (busy) cnt++; end
        check(cnt == 0, "R10 unselected write", cnt, 0);

        // R9 status read while idle, and no write caused
        status_read("R9 status idle");
        repeat (6) @(negedge clk);
        check(busy == 0, "R9 read no write", busy, 0);

        // R5 R8 three back-to-back writes: second long busy, third overruns
        do_write(8'hC3, 8'hC3, 1'b1);
        do_write(8'h5A, 8'h5A, 1'b1);
        do_write(8'hE7, 8'hE7, 1'b1);
        status_read("R9 status busy");
        check(busy == 1, "R5 long busy", busy, 1);
        idle(30);
        check(overrun == 1, "R8 overrun set", overrun, 1);
        repeat (10) @(negedge clk);
        check(overrun == 1, "R8 overrun sticky", overrun, 1);

        // R6 seamless pair after overrun
        do_write(8'h81, 8'h81, 1'b1);
        do_write(8'h42, 8'h42, 1'b1);
        idle(40);

        // R1 reset clears overrun
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(overrun == 0 && busy == 0, "R1 reset clears", {overrun, busy}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule